// File: doc/BRIEF.md
# Retimed Graph Weight Evaluator

This block scores one candidate retiming of a small synchronous circuit graph. Each vertex carries a combinational delay. Each directed edge carries a register count. A signed retiming integer per vertex moves registers across that vertex. When a start pulse is accepted, the block captures the graph and the retiming vector. It forms every retimed edge weight and marks each edge whose weight has gone below zero. It then searches for the slowest register-free chain: the largest sum of vertex delays along any path whose edges all hold zero registers after retiming. That sum is the clock period the retimed circuit would need.

The search is iterative relaxation over the zero-weight edges. Every edge is relaxed in parallel once per clock cycle. A legal retiming leaves these edges acyclic, so the values stop changing within the vertex count of passes. If they still change on the final allowed pass, a register-free loop exists and the block raises an error flag instead of a period.

Control is plain level-and-pulse signalling, with no valid/ready flow. A start pulse is taken only while the block is idle. `busy_o` is high during the search. `done_o` then rises and holds every result steady until the next accepted start. There is no back-pressure, because results simply wait on the outputs.

Top module: `retime_eval`

## Requirements
- R1: On an accepted start, each edge e from vertex s to vertex d gets the retimed weight w_e + r_d - r_s. It appears on `ret_w_o[e*10 +: 10]` as a 10-bit two's-complement value. Edge weights, retiming values and endpoint indices are taken from slot e (bits e*8 and e*2) and slot v (bits v*8) of the packed inputs.
- R2: Bit e of `neg_mask_o` is 1 exactly when retimed weight e is negative. `legal_o` is 1 exactly when no bit of `neg_mask_o` is set.
- R3: When `done_o` is high and `cyc_err_o` is low, `period_o` is the largest total vertex delay over any path whose edges all have retimed weight zero. A single vertex counts as a path, and edges with non-zero weight, including negative ones, break a path.
- R4: If the zero-weight edges form a cycle through at least one vertex of non-zero delay, the result has `cyc_err_o` = 1 and `period_o` = 0.
- R5: A start seen while `busy_o` is low makes `busy_o` 1 and `done_o` 0 in the next cycle. `busy_o` stays high for at most NV cycles and then drops as `done_o` rises. The two are never high together.
- R6: A start pulse while `busy_o` is high is ignored, and the running evaluation finishes with its original inputs.
- R7: After completion, `done_o` and all results hold unchanged until the next accepted start.
- R8: After reset, `busy_o`, `done_o`, `legal_o`, `cyc_err_o` and `period_o` are all zero.
- R9: Inputs are sampled only in the cycle of an accepted start. Later changes to them do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Single-cycle request to evaluate |
| vtx_delay_i | input | NV*16 | Unsigned delay per vertex |
| edge_src_i | input | NE*IW | Source vertex index per edge |
| edge_dst_i | input | NE*IW | Destination vertex index per edge |
| edge_w_i | input | NE*8 | Signed register count per edge |
| retime_i | input | NV*8 | Signed retiming value per vertex |
| busy_o | output | 1 | Evaluation in progress |
| done_o | output | 1 | Results valid |
| legal_o | output | 1 | No retimed weight is negative |
| cyc_err_o | output | 1 | Register-free loop detected |
| period_o | output | 16+clog2(NV+1) | Critical path delay |
| neg_mask_o | output | NE | Per-edge negative-weight flag |
| ret_w_o | output | NE*10 | Retimed weight per edge, signed |

## Verification
The properties assume that every edge endpoint index is below NV and that start is a short pulse sampled on clock edges. With those assumptions, the handshake ordering and the bounded search length follow from the control logic alone. The stimulus uses one fixed four-vertex loop with indices 0 to 3 and drives every input half a cycle away from the active edge. It varies only the retiming vector and the edge weights, including values at both ends of the 8-bit range and a graph whose edges are all zero. It deliberately pulses start during a busy interval and changes the inputs right after a start, so the properties on ignored requests and held results are actually stimulated.

// File: rtl/retime_eval_pkg.sv
package retime_eval_pkg;
  localparam int RW_DEF = 8;
  localparam int DW_DEF = 16;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/retime_wcalc.sv
module retime_wcalc #(
  parameter int NV = 4,
  parameter int NE = 4,
  parameter int RW = 8,
  parameter int IW = 2,
  parameter int XW = RW + 2
) (
  input  logic [NE*IW-1:0] src,
  input  logic [NE*IW-1:0] dst,
  input  logic [NE*RW-1:0] w,
  input  logic [NV*RW-1:0] r,
  output logic [NE*XW-1:0] rw,
  output logic [NE-1:0]    neg,
  output logic [NE-1:0]    zero
);
  for (genvar e = 0; e < NE; e++) begin : g_edge
    logic [IW-1:0]        s_idx, d_idx;
    logic [RW-1:0]        w_raw, rs_raw, rd_raw;
    logic signed [XW-1:0] w_x, rs_x, rd_x, sum;
    assign s_idx  = src[e*IW +: IW];
    assign d_idx  = dst[e*IW +: IW];
    assign w_raw  = w[e*RW +: RW];
    assign rs_raw = r[int'(s_idx)*RW +: RW];
    assign rd_raw = r[int'(d_idx)*RW +: RW];
    assign w_x    = {{(XW-RW){w_raw[RW-1]}}, w_raw};
    assign rs_x   = {{(XW-RW){rs_raw[RW-1]}}, rs_raw};
    assign rd_x   = {{(XW-RW){rd_raw[RW-1]}}, rd_raw};
    assign sum    = w_x + rd_x - rs_x;
    assign rw[e*XW +: XW] = sum;
    assign neg[e]  = sum[XW-1];
    assign zero[e] = (sum == '0);
  end
endmodule

// File: rtl/retime_relax.sv
module retime_relax #(
  parameter int NV = 4,
  parameter int NE = 4,
  parameter int IW = 2,
  parameter int DW = 16,
  parameter int PW = 19
) (
  input  logic [NV-1:0][PW-1:0] arr,
  input  logic [NV-1:0][DW-1:0] dly,
  input  logic [NE-1:0]         zero,
  input  logic [NE*IW-1:0]      src,
  input  logic [NE*IW-1:0]      dst,
  output logic [NV-1:0][PW-1:0] nxt,
  output logic                  changed
);
  logic [PW-1:0] cand;

  always_comb begin
    nxt  = arr;
    cand = '0;
    for (int v = 0; v < NV; v++) begin
      for (int e = 0; e < NE; e++) begin
        if (zero[e] && (dst[e*IW +: IW] == IW'(v))) begin
          cand = arr[src[e*IW +: IW]] + PW'(dly[v]);
          if (cand > nxt[v]) nxt[v] = cand;
        end
      end
    end
    changed = (nxt != arr);
  end
endmodule

// File: rtl/retime_peak.sv
module retime_peak #(
  parameter int NV = 4,
  parameter int PW = 19
) (
  input  logic [NV-1:0][PW-1:0] arr,
  output logic [PW-1:0]         peak
);
  always_comb begin
    peak = '0;
    for (int v = 0; v < NV; v++)
      if (arr[v] > peak) peak = arr[v];
  end
endmodule

// File: rtl/retime_eval.sv
module retime_eval
  import retime_eval_pkg::*;
#(
  parameter int NV = 4,
  parameter int NE = 4,
  parameter int RW = RW_DEF,
  parameter int DW = DW_DEF,
  localparam int IW = idx_w(NV),
  localparam int XW = RW + 2,
  localparam int PW = DW + $clog2(NV + 1),
  localparam int CW = $clog2(NV + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NV*DW-1:0] vtx_delay_i,
  input  logic [NE*IW-1:0] edge_src_i,
  input  logic [NE*IW-1:0] edge_dst_i,
  input  logic [NE*RW-1:0] edge_w_i,
  input  logic [NV*RW-1:0] retime_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             legal_o,
  output logic             cyc_err_o,
  output logic [PW-1:0]    period_o,
  output logic [NE-1:0]    neg_mask_o,
  output logic [NE*XW-1:0] ret_w_o
);
  logic [NE*XW-1:0]      rw_c;
  logic [NE-1:0]         neg_c, zero_c;
  logic [NE*IW-1:0]      src_q, dst_q;
  logic [NV-1:0][DW-1:0] dly_q;
  logic [NV-1:0][PW-1:0] arr_q, arr_nxt;
  logic [NE-1:0]         zero_q;
  logic                  changed;
  logic [PW-1:0]         peak;
  logic [CW-1:0]         pass_q;
  logic                  go;

  assign go = start && !busy_o;

  retime_wcalc #(.NV(NV), .NE(NE), .RW(RW), .IW(IW), .XW(XW)) wcalc_i (
    .src(edge_src_i), .dst(edge_dst_i), .w(edge_w_i), .r(retime_i),
    .rw(rw_c), .neg(neg_c), .zero(zero_c)
  );

  retime_relax #(.NV(NV), .NE(NE), .IW(IW), .DW(DW), .PW(PW)) relax_i (
    .arr(arr_q), .dly(dly_q), .zero(zero_q), .src(src_q), .dst(dst_q),
    .nxt(arr_nxt), .changed(changed)
  );

  retime_peak #(.NV(NV), .PW(PW)) peak_i (.arr(arr_nxt), .peak(peak));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      legal_o    <= 1'b0;
      cyc_err_o  <= 1'b0;
      period_o   <= '0;
      neg_mask_o <= '0;
      ret_w_o    <= '0;
      src_q      <= '0;
      dst_q      <= '0;
      dly_q      <= '0;
      arr_q      <= '0;
      zero_q     <= '0;
      pass_q     <= '0;
    end else if (go) begin
      busy_o     <= 1'b1;
      done_o     <= 1'b0;
      cyc_err_o  <= 1'b0;
      legal_o    <= ~|neg_c;
      neg_mask_o <= neg_c;
      ret_w_o    <= rw_c;
      zero_q     <= zero_c;
      src_q      <= edge_src_i;
      dst_q      <= edge_dst_i;
      pass_q     <= '0;
      for (int v = 0; v < NV; v++) begin
        dly_q[v] <= vtx_delay_i[v*DW +: DW];
        arr_q[v] <= PW'(vtx_delay_i[v*DW +: DW]);
      end
    end else if (busy_o) begin
      arr_q  <= arr_nxt;
      pass_q <= pass_q + 1'b1;
      if (!changed) begin
        busy_o   <= 1'b0;
        done_o   <= 1'b1;
        period_o <= peak;
      end else if (pass_q == CW'(NV - 1)) begin
        busy_o    <= 1'b0;
        done_o    <= 1'b1;
        cyc_err_o <= 1'b1;
        period_o  <= '0;
      end
    end
  end
endmodule

// File: rtl/retime_eval_chk.sv
module retime_eval_chk #(
  parameter int NV = 4,
  parameter int NE = 4,
  parameter int XW = 10,
  parameter int PW = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy_o,
  input logic             done_o,
  input logic             legal_o,
  input logic             cyc_err_o,
  input logic [PW-1:0]    period_o,
  input logic [NE-1:0]    neg_mask_o,
  input logic [NE*XW-1:0] ret_w_o
);
  int busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_cnt <= 0;
    else        busy_cnt <= busy_o ? busy_cnt + 1 : 0;
  end

  // R5
  start_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_o) |=> (busy_o && !done_o));
  // R5
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (busy_cnt < NV));
  // R5
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));
  // R6
  busy_start_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start) |=> ($stable(ret_w_o) && $stable(neg_mask_o) && $stable(legal_o)));
  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start) |=> (done_o && $stable(period_o) && $stable(legal_o) && $stable(cyc_err_o)));
  // R4
  err_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cyc_err_o) |-> (period_o == '0));
  // R2
  legal_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (legal_o == (neg_mask_o == '0)));
endmodule

bind retime_eval retime_eval_chk #(.NV(NV), .NE(NE), .XW(XW), .PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy_o(busy_o), .done_o(done_o),
  .legal_o(legal_o), .cyc_err_o(cyc_err_o), .period_o(period_o),
  .neg_mask_o(neg_mask_o), .ret_w_o(ret_w_o)
);

// File: tb/retime_eval_tb_top.sv
module retime_eval_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;
  localparam int NE = 4;
  localparam int IW = 2;
  localparam int PW = 16 + $clog2(NV + 1);
  localparam int NT = 6;

  // retime bytes: vertex v at bits v*8 (0=h 1=a 2=b 3=c)
  localparam logic [31:0] TV_R [NT] = '{32'h00000000, 32'h00010000, 32'h00000100,
                                        32'hFF000000, 32'h02020202, 32'h000100FF};
  localparam int TV_P [NT] = '{15, 10, 10, 20, 15, 10};
  localparam bit TV_L [NT] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [NV*16-1:0] vtx_delay;
  logic [NE*IW-1:0] edge_src, edge_dst;
  logic [NE*8-1:0]  edge_w;
  logic [NV*8-1:0]  retime;
  logic busy, done, legal, cyc_err;
  logic [PW-1:0] period;
  logic [NE-1:0] neg_mask;
  logic [NE*10-1:0] ret_w;

  int checks = 0, failures = 0;
  int src_v [NE] = '{0, 1, 2, 3};
  int dst_v [NE] = '{1, 2, 3, 0};
  int dly_v [NV] = '{0, 10, 5, 5};
  int cur_w [NE];
  int cur_r [NV];

  always #(CLK_PERIOD/2) clk = ~clk;

  retime_eval #(.NV(NV), .NE(NE)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .vtx_delay_i(vtx_delay),
    .edge_src_i(edge_src), .edge_dst_i(edge_dst), .edge_w_i(edge_w),
    .retime_i(retime), .busy_o(busy), .done_o(done), .legal_o(legal),
    .cyc_err_o(cyc_err), .period_o(period), .neg_mask_o(neg_mask), .ret_w_o(ret_w)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_inputs();
    for (int v = 0; v < NV; v++) begin
      vtx_delay[v*16 +: 16] = 16'(dly_v[v]);
      retime[v*8 +: 8] = 8'(cur_r[v]);
    end
    for (int e = 0; e < NE; e++) begin
      edge_src[e*IW +: IW] = IW'(src_v[e]);
      edge_dst[e*IW +: IW] = IW'(dst_v[e]);
      edge_w[e*8 +: 8] = 8'(cur_w[e]);
    end
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 50) begin
      @(negedge clk);
      n++;
    end
    check(done && n <= NV, req, n, NV);
  endtask

  task automatic run_eval();
    @(negedge clk);
    drive_inputs();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !done, "R5 busy after start", {busy, done}, 2);
    wait_done("R5 completion within NV cycles");
  endtask

  task automatic check_weights(input string tag);
    bit any_neg = 0;
    for (int e = 0; e < NE; e++) begin
      int ew = cur_w[e] + cur_r[dst_v[e]] - cur_r[src_v[e]];
      int aw = int'($signed(ret_w[e*10 +: 10]));
      check(aw == ew, {"R1 weight ", tag}, aw, ew);
      check(neg_mask[e] == (ew < 0), {"R2 neg bit ", tag}, neg_mask[e], ew < 0);
      if (ew < 0) any_neg = 1;
    end
    check(legal == !any_neg, {"R2 legal ", tag}, legal, !any_neg);
  endtask

  task automatic base_graph();
    cur_w = '{0, 0, 1, 1};
    cur_r = '{0, 0, 0, 0};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    base_graph();
    drive_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check(!busy && !done && !legal && !cyc_err && period == 0, "R8 reset outputs",
          {busy, done, legal, cyc_err}, 0);

    // table walk: R1 R2 R3
    for (int i = 0; i < NT; i++) begin
      base_graph();
      for (int v = 0; v < NV; v++) cur_r[v] = int'($signed(TV_R[i][v*8 +: 8]));
      run_eval();
      check_weights($sformatf("vec%0d", i));
      check(legal == TV_L[i], "R2 legal table", legal, TV_L[i]);
      check(!cyc_err, "R4 no loop", cyc_err, 0);
      check(period == PW'(TV_P[i]), "R3 period", period, TV_P[i]);
    end

    // R7 hold after done
    repeat (5) @(negedge clk);
    check(done && period == PW'(10) && legal, "R7 results held", period, 10);

    // R4 all edges zero: register-free loop
    cur_w = '{0, 0, 0, 0};
    cur_r = '{0, 0, 0, 0};
    run_eval();
    check(cyc_err == 1'b1, "R4 loop flag", cyc_err, 1);
    check(period == 0, "R4 period zero", period, 0);

    // R1 extreme values
    base_graph();
    cur_w[0] = 127;
    cur_r = '{-128, 127, 0, 0};
    run_eval();
    check_weights("extreme");
    check(int'($signed(ret_w[9:0])) == 382, "R1 max weight", int'($signed(ret_w[9:0])), 382);

    // R6 start while busy is ignored
    base_graph();
    @(negedge clk);
    drive_inputs();
    start = 1'b1;
    @(negedge clk);
    cur_r = '{0, 0, 1, 0};
    drive_inputs();
    check(busy, "R6 busy at second start", busy, 1);
    @(negedge clk);
    start = 1'b0;
    wait_done("R6 completion");
    check(period == PW'(15), "R6 period of first request", period, 15);
    check(int'($signed(ret_w[19:10])) == 0, "R6 weight of first request",
          int'($signed(ret_w[19:10])), 0);

    // R9 inputs changed right after start
    base_graph();
    @(negedge clk);
    drive_inputs();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cur_r = '{0, 1, 0, 0};
    dly_v = '{100, 100, 100, 100};
    drive_inputs();
    wait_done("R9 completion");
    check(period == PW'(15), "R9 period unaffected", period, 15);
    check(legal, "R9 legal unaffected", legal, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule